// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside an instruction prefetch queue and keeps the opening instruction words of recently taken branch targets. When the core issues a non-sequential fetch request, every stored target tag is compared with the requested address in the same cycle. On a hit, the block streams the stored words to the core, one word per handshake. At the same time, it tells the prefetch queue to restart at the first address past the stored words. On a miss, it claims the least recently used general entry. It then records the words that memory returns for the target, in arrival order.

The general region holds a parameter number of entries, four by default. Each entry stores a parameter number of words, four by default. One further entry belongs to the interrupt-vector fetch path alone. Requests flagged as vector fetches look up and fill only that entry. Ordinary branches neither match it nor evict it. A flush input invalidates every entry.

The word stream to the core uses valid/ready. A word is held, unchanged, on `out_data` while `out_valid` is high and `out_ready` is low. The stream moves to the next word only on a cycle with both signals high. The memory return path is observed but never back-pressured: the block simply captures `mem_data` on cycles where `mem_valid` is high while a fill is open. A new request ends any stream or fill that is in progress. Flush takes precedence over a request in the same cycle, and that request is then dropped.

Top module: `brtgt_cache`

## Requirements
- R1: After reset no entry is valid, `lookup_hit`, `lookup_miss`, `restart_valid` and `out_valid` are low, and the first request of either kind misses.
- R2: A request (`req_valid` high, `flush` low) yields exactly one of `lookup_hit` or `lookup_miss` as a one-cycle pulse in the cycle after the request; at most one entry matches.
- R3: After a hit, `out_valid` rises in the cycle after the request and the stored words appear on `out_data` in address order, advancing only on cycles with `out_valid` and `out_ready` both high; while `out_ready` is low the word and `out_valid` hold. After the last word is accepted, `out_valid` falls.
- R4: With every hit, `restart_valid` pulses in the same cycle as `lookup_hit`, and `restart_addr` equals the requested byte address plus 4 times the word count in bytes (16 by default). Addresses are word-aligned byte addresses.
- R5: On a miss, the words seen on `mem_data` in the cycles where `mem_valid` is high are stored in order, starting in the cycle after the request. The entry becomes valid only in the cycle its last word is stored, so a request for that target before then misses.
- R6: A miss on the general path replaces the general entry that was least recently looked up or allocated. A hit renews the recency of the entry it hits.
- R7: Requests with `req_vector` high use only the reserved vector entry. General requests never match it, and general allocations never replace it.
- R8: A one-cycle `flush` pulse invalidates every entry, including the vector entry, and ends any open stream or fill.
- R9: A new request while a fill is open abandons that fill. The partially written entry stays invalid.
- R10: `mem_valid` words arriving while no fill is open leave all stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Non-sequential fetch request strobe |
| req_vector | input | 1 | Request belongs to the interrupt-vector path |
| req_addr | input | AW | Requested target byte address |
| lookup_hit | output | 1 | Pulse: last request hit |
| lookup_miss | output | 1 | Pulse: last request missed |
| restart_valid | output | 1 | Pulse: prefetch queue should restart |
| restart_addr | output | AW | Restart address for the prefetch queue |
| mem_valid | input | 1 | Memory return word present |
| mem_data | input | DW | Memory return word |
| out_valid | output | 1 | Stored word offered to the core |
| out_ready | input | 1 | Core accepts the offered word |
| out_data | output | DW | Stored instruction word |

## Verification
The bench builds the block with the default parameters: four general entries, four 32-bit words per entry and 32-bit addresses. With only four general entries, a fifth distinct target forces an eviction after a few fills. This makes it possible to check the least-recently-used choice directly, including the effect of an intervening hit on that choice. Four words per entry keeps each stream and fill short. That leaves room to hold back-pressure in the middle of a stream, to abandon a fill partway and to fill the vector entry, all within short directed scenarios.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    BRC_IDLE   = 2'd0,
    BRC_STREAM = 2'd1,
    BRC_FILL   = 2'd2
  } brc_mode_e;
endpackage

// File: rtl/brc_tag_match.sv
module brc_tag_match #(
  parameter int NENT = 5,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NENT)
) (
  input  logic [NENT-1:0][AW-1:0] tags_i,
  input  logic [NENT-1:0]         live_i,
  input  logic [AW-1:0]           addr_i,
  output logic [NENT-1:0]         match_o,
  output logic                    any_o,
  output logic [IW-1:0]           idx_o
);
  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign match_o[g] = live_i[g] && (tags_i[g] == addr_i);
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NENT; i++) begin
      if (match_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/brc_age_lru.sv
module brc_age_lru #(
  parameter int NGEN = 4,
  localparam int GW  = $clog2(NGEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_i,
  input  logic [GW-1:0] touch_idx_i,
  output logic [GW-1:0] victim_o
);
  logic [NGEN-1:0][GW-1:0] age_q, age_d;
  logic [NGEN-1:0]         oldest;

  always_comb begin
    age_d = age_q;
    if (touch_i) begin
      for (int i = 0; i < NGEN; i++) begin
        if (GW'(i) == touch_idx_i) age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    oldest   = '0;
    for (int i = 0; i < NGEN; i++) begin
      if (age_q[i] == GW'(NGEN - 1)) begin
        oldest[i] = 1'b1;
        victim_o  = GW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGEN; i++) age_q[i] <= GW'(i);
    end else begin
      age_q <= age_d;
    end
  end

  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest));

  assert_touch_youngest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/brc_store.sv
module brc_store #(
  parameter int NENT   = 5,
  parameter int NWORDS = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  localparam int EW    = $clog2(NENT),
  localparam int WW    = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic                    alloc_i,
  input  logic [EW-1:0]           alloc_ent_i,
  input  logic [AW-1:0]           alloc_tag_i,
  input  logic                    wr_i,
  input  logic [EW-1:0]           wr_ent_i,
  input  logic [WW-1:0]           wr_word_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic                    commit_i,
  input  logic [EW-1:0]           rd_ent_i,
  input  logic [WW-1:0]           rd_word_i,
  output logic [NENT-1:0][AW-1:0] tags_o,
  output logic [NENT-1:0]         valid_o,
  output logic [DW-1:0]           rd_data_o
);
  logic [DW-1:0] data_q [NENT][NWORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= '0;
      tags_o  <= '0;
    end else if (flush_i) begin
      valid_o <= '0;
    end else begin
      if (alloc_i) begin
        valid_o[alloc_ent_i] <= 1'b0;
        tags_o[alloc_ent_i]  <= alloc_tag_i;
      end
      if (commit_i) valid_o[wr_ent_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) data_q[wr_ent_i][wr_word_i] <= wr_data_i;
  end

  assign rd_data_o = data_q[rd_ent_i][rd_word_i];

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> valid_o == '0);

  assert_commit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && !flush_i |=> valid_o[$past(wr_ent_i)]);
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NGEN   = 4,
  parameter int NWORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req_valid,
  input  logic          req_vector,
  input  logic [AW-1:0] req_addr,
  output logic          lookup_hit,
  output logic          lookup_miss,
  output logic          restart_valid,
  output logic [AW-1:0] restart_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import brc_pkg::*;

  localparam int NENT       = NGEN + 1;
  localparam int EW         = $clog2(NENT);
  localparam int GW         = $clog2(NGEN);
  localparam int WW         = $clog2(NWORDS);
  localparam int VEC_ENT    = NGEN;
  localparam int LINE_BYTES = NWORDS * DW / 8;
  localparam logic [NENT-1:0] VEC_MASK = NENT'(1) << VEC_ENT;

  brc_mode_e     mode_q;
  logic [EW-1:0] sel_q;
  logic [WW-1:0] widx_q;
  logic          last_word;

  logic [NENT-1:0][AW-1:0] tags;
  logic [NENT-1:0]         valid;
  logic [NENT-1:0]         live;
  logic [NENT-1:0]         match_vec;
  logic                    hit_any;
  logic [EW-1:0]           hit_idx;
  logic [GW-1:0]           victim;
  logic                    req_fire;
  logic                    alloc;
  logic [EW-1:0]           alloc_ent;
  logic                    wr;
  logic                    commit;

  assign req_fire  = req_valid && !flush;
  assign live      = req_vector ? (valid & VEC_MASK) : (valid & ~VEC_MASK);
  assign last_word = (widx_q == WW'(NWORDS - 1));

  brc_tag_match #(.NENT(NENT), .AW(AW)) u_match (
    .tags_i  (tags),
    .live_i  (live),
    .addr_i  (req_addr),
    .match_o (match_vec),
    .any_o   (hit_any),
    .idx_o   (hit_idx)
  );

  brc_age_lru #(.NGEN(NGEN)) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_i     (req_fire && !req_vector),
    .touch_idx_i (hit_any ? hit_idx[GW-1:0] : victim),
    .victim_o    (victim)
  );

  assign alloc     = req_fire && !hit_any;
  assign alloc_ent = req_vector ? EW'(VEC_ENT) : EW'(victim);
  assign wr        = (mode_q == BRC_FILL) && mem_valid && !flush && !req_valid;
  assign commit    = wr && last_word;

  brc_store #(.NENT(NENT), .NWORDS(NWORDS), .AW(AW), .DW(DW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush),
    .alloc_i     (alloc),
    .alloc_ent_i (alloc_ent),
    .alloc_tag_i (req_addr),
    .wr_i        (wr),
    .wr_ent_i    (sel_q),
    .wr_word_i   (widx_q),
    .wr_data_i   (mem_data),
    .commit_i    (commit),
    .rd_ent_i    (sel_q),
    .rd_word_i   (widx_q),
    .tags_o      (tags),
    .valid_o     (valid),
    .rd_data_o   (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= BRC_IDLE;
      sel_q         <= '0;
      widx_q        <= '0;
      lookup_hit    <= 1'b0;
      lookup_miss   <= 1'b0;
      restart_valid <= 1'b0;
      restart_addr  <= '0;
    end else begin
      lookup_hit    <= 1'b0;
      lookup_miss   <= 1'b0;
      restart_valid <= 1'b0;
      if (flush) begin
        mode_q <= BRC_IDLE;
        widx_q <= '0;
      end else if (req_fire) begin
        widx_q <= '0;
        if (hit_any) begin
          mode_q        <= BRC_STREAM;
          sel_q         <= hit_idx;
          lookup_hit    <= 1'b1;
          restart_valid <= 1'b1;
          restart_addr  <= req_addr + AW'(LINE_BYTES);
        end else begin
          mode_q      <= BRC_FILL;
          sel_q       <= alloc_ent;
          lookup_miss <= 1'b1;
        end
      end else begin
        case (mode_q)
          BRC_STREAM: if (out_ready) begin
            if (last_word) mode_q <= BRC_IDLE;
            else           widx_q <= widx_q + 1'b1;
          end
          BRC_FILL: if (mem_valid) begin
            if (last_word) mode_q <= BRC_IDLE;
            else           widx_q <= widx_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign out_valid = (mode_q == BRC_STREAM);

  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (lookup_hit != lookup_miss));

  assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> $onehot0(match_vec));

  assert_restart_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |-> restart_valid && restart_addr == $past(req_addr) + AW'(LINE_BYTES));

  assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !req_valid && !flush |=> out_valid && $stable(out_data));

  assert_vector_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_hit || lookup_miss) |-> ((sel_q == EW'(VEC_ENT)) == $past(req_vector)));

  assert_fill_abandon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BRC_FILL) && req_fire |=> widx_q == '0);
endmodule

// File: tb/brtgt_cache_bench.sv
module brtgt_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_vector = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          lookup_hit, lookup_miss, restart_valid, out_valid;
  logic [AW-1:0] restart_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_data = '0;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brtgt_cache u_brtgt_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_vector(req_vector), .req_addr(req_addr),
    .lookup_hit(lookup_hit), .lookup_miss(lookup_miss),
    .restart_valid(restart_valid), .restart_addr(restart_addr),
    .mem_valid(mem_valid), .mem_data(mem_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] wv(input logic [31:0] a, input int i);
    return (a ^ 32'hC0DE_0000) + 32'(i) * 32'h0101_0011;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic issue(input logic [31:0] a, input bit vec);
    req_valid  = 1'b1;
    req_vector = vec;
    req_addr   = a;
    @(negedge clk);
    req_valid  = 1'b0;
    req_vector = 1'b0;
  endtask

  task automatic expect_miss(input logic [31:0] a, input bit vec, input int nfill, input string tag);
    issue(a, vec);
    chk(lookup_miss && !lookup_hit, {tag, " miss"}, {62'd0, lookup_hit, lookup_miss}, 64'd1);
    chk(!restart_valid && !out_valid, {tag, " no stream on miss"}, {62'd0, restart_valid, out_valid}, 64'd0);
    for (int i = 0; i < nfill; i++) begin
      mem_valid = 1'b1;
      mem_data  = wv(a, i);
      @(negedge clk);
    end
    mem_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input bit vec, input string tag);
    issue(a, vec);
    chk(lookup_hit && !lookup_miss, {tag, " hit"}, {62'd0, lookup_hit, lookup_miss}, 64'd2);
    chk(restart_valid && restart_addr == a + 32'd16, {tag, " R4 restart"}, {31'd0, restart_valid, restart_addr}, {31'd0, 1'b1, a + 32'd16});
    for (int i = 0; i < NW; i++) begin
      chk(out_valid && out_data == wv(a, i), {tag, " R3 word"}, {31'd0, out_valid, out_data}, {31'd0, 1'b1, wv(a, i)});
      @(negedge clk);
    end
    chk(!out_valid, {tag, " R3 stream end"}, {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset;
    chk(!lookup_hit && !lookup_miss && !restart_valid && !out_valid, "R1 idle outputs",
        {60'd0, lookup_hit, lookup_miss, restart_valid, out_valid}, 64'd0);
    expect_miss(32'h0000_1000, 1'b1, 0, "R1 vector first");
    expect_miss(32'h0000_1000, 1'b0, 4, "R1 general first");
  endtask

  task automatic t_hit;
    expect_hit(32'h0000_1000, 1'b0, "R2 R5 filled target");
  endtask

  task automatic t_backpressure;
    logic [31:0] a = 32'h0000_1000;
    issue(a, 1'b0);
    out_ready = 1'b0;
    chk(lookup_hit, "R3 bp hit", {63'd0, lookup_hit}, 64'd1);
    for (int k = 0; k < 3; k++) begin
      chk(out_valid && out_data == wv(a, 0), "R3 held word", {31'd0, out_valid, out_data}, {31'd0, 1'b1, wv(a, 0)});
      @(negedge clk);
    end
    out_ready = 1'b1;
    for (int i = 0; i < NW; i++) begin
      chk(out_valid && out_data == wv(a, i), "R3 bp word", {31'd0, out_valid, out_data}, {31'd0, 1'b1, wv(a, i)});
      @(negedge clk);
    end
    chk(!out_valid, "R3 bp end", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_partial;
    expect_miss(32'h0000_2000, 1'b0, 3, "R5 partial");
    expect_miss(32'h0000_2000, 1'b0, 4, "R5 incomplete not valid");
    expect_hit(32'h0000_2000, 1'b0, "R5 complete");
  endtask

  task automatic t_abandon;
    expect_miss(32'h0000_3000, 1'b0, 2, "R9 start");
    expect_miss(32'h0000_3400, 1'b0, 4, "R9 interrupting");
    expect_miss(32'h0000_3000, 1'b0, 4, "R9 abandoned stays invalid");
    expect_hit(32'h0000_3400, 1'b0, "R9 new fill");
  endtask

  task automatic t_lru;
    expect_miss(32'h0000_4000, 1'b0, 4, "R6 C");
    expect_miss(32'h0000_4100, 1'b0, 4, "R6 D");
    expect_miss(32'h0000_4200, 1'b0, 4, "R6 E");
    expect_miss(32'h0000_4300, 1'b0, 4, "R6 F");
    expect_hit(32'h0000_4000, 1'b0, "R6 refresh C");
    expect_miss(32'h0000_4400, 1'b0, 4, "R6 G");
    expect_hit(32'h0000_4200, 1'b0, "R6 E kept");
    expect_hit(32'h0000_4300, 1'b0, "R6 F kept");
    expect_hit(32'h0000_4000, 1'b0, "R6 C kept");
    expect_hit(32'h0000_4400, 1'b0, "R6 G kept");
    expect_miss(32'h0000_4100, 1'b0, 0, "R6 D evicted");
  endtask

  task automatic t_vector;
    logic [31:0] v = 32'h0000_0018;
    expect_miss(v, 1'b1, 4, "R7 vector fill");
    expect_hit(v, 1'b1, "R7 vector hit");
    expect_miss(v, 1'b0, 0, "R7 general ignores vector");
    expect_miss(32'h0000_5000, 1'b0, 4, "R7 H");
    expect_miss(32'h0000_5100, 1'b0, 4, "R7 I");
    expect_miss(32'h0000_5200, 1'b0, 4, "R7 J");
    expect_miss(32'h0000_5300, 1'b0, 4, "R7 K");
    expect_hit(v, 1'b1, "R7 vector survives");
  endtask

  task automatic t_mem_ignored;
    mem_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      mem_data = 32'hDEAD_0000 + 32'(k);
      @(negedge clk);
    end
    mem_data = 32'hBAD0_BAD0;
    expect_hit(32'h0000_5300, 1'b0, "R10 idle words");
    expect_hit(32'h0000_5300, 1'b0, "R10 words during stream");
    mem_valid = 1'b0;
  endtask

  task automatic t_flush;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    expect_miss(32'h0000_0018, 1'b1, 0, "R8 vector flushed");
    expect_miss(32'h0000_5300, 1'b0, 0, "R8 general flushed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_backpressure();
    t_partial();
    t_abandon();
    t_lru();
    t_vector();
    t_mem_ignored();
    t_flush();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule